// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address stream for a pipeline whose instruction set has a fixed architectural branch shadow of two instructions. Each cycle it presents one word address and a valid bit for the instruction being fetched. The decode stage reports a resolved branch one cycle after that branch was fetched. The report carries four items: a valid strobe, the taken outcome, a "likely" hint and a target address. The two words that follow the branch are always fetched. The target, if taken, is fetched in the cycle right after the second shadow word, so the fetch stream has no gap and nothing is flushed.

For a likely-hinted branch that resolves not-taken, the two shadow words still enter the pipeline, but their valid bit is cleared so they never commit. A branch reported for an instruction that was itself in a shadow is treated as illegal. It has no effect on the fetch stream, and an error flag rises for one cycle. An asynchronous active-low reset returns the address to a parameterised vector and drops any pending redirect.

Top module: `dbs_fetch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_o` equals RESET_VEC, `slot_o` is 0, `fetch_valid_o` is 1 and `bad_br_o` is 0.
- R2: When no redirect is due, `pc_o` advances by 4 each cycle.
- R3: A legal branch report in a cycle marks that cycle's fetch as shadow word 1 (`slot_o`=1) and the next fetch as shadow word 2 (`slot_o`=2), at the two sequential addresses following the branch. `slot_o`=0 outside a shadow.
- R4: For a taken branch, the fetch in the cycle after shadow word 2 is the target, with no idle or repeated cycle between them.
- R5: For a branch without the likely hint, both shadow words have `fetch_valid_o`=1, whether the branch is taken or not.
- R6: For a likely-hinted branch that is not taken, both shadow words have `fetch_valid_o`=0, and fetching continues at branch+12.
- R7: For a likely-hinted branch that is taken, both shadow words have `fetch_valid_o`=1, and the target follows them.
- R8: A branch report whose branch was fetched as a shadow word (that is, `slot_o` was nonzero in the previous cycle) changes neither the address stream nor the valid bits. `bad_br_o` is 1 in the next cycle only.
- R9: The two low bits of `br_target_i` are ignored. The redirect address has them cleared.
- R10: Reset asserted during a shadow cancels the pending redirect. After release, fetching runs sequentially from RESET_VEC.
- R11: A branch placed at a branch target is accepted normally, so taken branches can follow each other every three fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Decode reports a branch fetched in the previous cycle |
| br_taken_i | input | 1 | Resolved outcome of the reported branch |
| br_likely_i | input | 1 | Branch carries the likely hint (annul shadow if not taken) |
| br_target_i | input | AW | Branch destination address |
| pc_o | output | AW | Address fetched this cycle |
| fetch_valid_o | output | 1 | Fetched word will commit; 0 for annulled shadow words |
| slot_o | output | $clog2(NUM_SLOTS+1) | Shadow position of this fetch: 0 none, 1 or 2 |
| bad_br_o | output | 1 | One-cycle pulse after an illegal branch-in-shadow report |

## Verification
The hardest situation to reach is a branch report that arrives while an earlier branch's redirect is still pending. This must leave the stored target and annul state untouched. The stimulus reaches it by reporting a taken branch, and then reporting further branches in each of the two following cycles, each with a different target. The bench then checks that the first target is still fetched on time and that each illegal report raises exactly one error pulse. A reset pulse during shadow word 1 with a taken redirect pending covers the other hidden-state case. After release, the sequential stream must not jump to the stale target.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned INSN_SHIFT = 2;

  typedef struct packed {
    logic taken;
    logic kill;
  } shadow_flags_t;
endpackage

// File: rtl/dbs_slot_ctr.sv
module dbs_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned SW = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_acc_i,
  output logic [SW-1:0] cur_slot_o,
  output logic [SW-1:0] prev_slot_o,
  output logic          fresh_o,
  output logic          last_o
);
  localparam logic [SW-1:0] LastSlot = SW'(NUM_SLOTS);
  localparam logic [SW-1:0] OneSlot  = SW'(1);

  logic [SW-1:0] cnt_q;

  // cnt_q holds the shadow index of the current fetch once past word 1
  assign fresh_o    = (cnt_q == '0);
  assign cur_slot_o = fresh_o ? (br_acc_i ? OneSlot : '0) : cnt_q;
  assign last_o     = (cur_slot_o == LastSlot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      prev_slot_o <= '0;
    end else begin
      prev_slot_o <= cur_slot_o;
      if (last_o)                 cnt_q <= '0;
      else if (cur_slot_o != '0)  cnt_q <= cur_slot_o + OneSlot;
    end
  end

  a_r3_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_slot_o != '0 && !last_o) |=> (cur_slot_o == $past(cur_slot_o) + OneSlot));

  a_r3_slot_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> fresh_o);
endmodule

// File: rtl/dbs_shadow_reg.sv
module dbs_shadow_reg
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_acc_i,
  input  logic          fresh_i,
  input  logic          last_i,
  input  logic          br_taken_i,
  input  logic          br_likely_i,
  input  logic [AW-1:0] br_target_i,
  output logic          taken_o,
  output logic          kill_o,
  output logic [AW-1:0] tgt_o
);
  shadow_flags_t flags_q, flags_live;
  logic [AW-1:0] tgt_q, tgt_live;

  assign tgt_live         = {br_target_i[AW-1:INSN_SHIFT], {INSN_SHIFT{1'b0}}};
  assign flags_live.taken = br_taken_i;
  assign flags_live.kill  = br_likely_i & ~br_taken_i;

  // in the resolving cycle the live report applies, afterwards the stored one
  assign taken_o = fresh_i ? flags_live.taken : flags_q.taken;
  assign kill_o  = fresh_i ? flags_live.kill  : flags_q.kill;
  assign tgt_o   = fresh_i ? tgt_live         : tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      tgt_q   <= '0;
    end else if (br_acc_i) begin
      flags_q <= flags_live;
      tgt_q   <= tgt_live;
    end else if (last_i) begin
      flags_q <= '0;
    end
  end

  a_r8_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fresh_i && !last_i) |=> ($stable(flags_q) && $stable(tgt_q)));

  a_r9_tgt_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o[INSN_SHIFT-1:0] == '0);
endmodule

// File: rtl/dbs_pc_reg.sv
module dbs_pc_reg
  import dbs_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 'h100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redir_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] Step = AW'(INSN_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_o <= RESET_VEC;
    else if (redir_i) pc_o <= tgt_i;
    else              pc_o <= pc_o + Step;
  end

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir_i |=> (pc_o == $past(pc_o) + Step));

  a_r4_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> (pc_o == $past(tgt_i)));
endmodule

// File: rtl/dbs_fetch_seq.sv
module dbs_fetch_seq #(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   NUM_SLOTS = 2,
  parameter logic [AW-1:0] RESET_VEC = 'h100,
  localparam int unsigned  SW        = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          br_valid_i,
  input  logic          br_taken_i,
  input  logic          br_likely_i,
  input  logic [AW-1:0] br_target_i,
  output logic [AW-1:0] pc_o,
  output logic          fetch_valid_o,
  output logic [SW-1:0] slot_o,
  output logic          bad_br_o
);
  logic [SW-1:0] cur_slot, prev_slot;
  logic          fresh, last;
  logic          br_acc, br_ill;
  logic          eff_taken, eff_kill, redirect;
  logic [AW-1:0] eff_tgt;

  // a report is legal only for a branch fetched outside any shadow
  assign br_acc = br_valid_i && (prev_slot == '0);
  assign br_ill = br_valid_i && (prev_slot != '0);

  dbs_slot_ctr #(.NUM_SLOTS(NUM_SLOTS)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .br_acc_i    (br_acc),
    .cur_slot_o  (cur_slot),
    .prev_slot_o (prev_slot),
    .fresh_o     (fresh),
    .last_o      (last)
  );

  dbs_shadow_reg #(.AW(AW)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .br_acc_i    (br_acc),
    .fresh_i     (fresh),
    .last_i      (last),
    .br_taken_i  (br_taken_i),
    .br_likely_i (br_likely_i),
    .br_target_i (br_target_i),
    .taken_o     (eff_taken),
    .kill_o      (eff_kill),
    .tgt_o       (eff_tgt)
  );

  assign redirect = last && eff_taken;

  dbs_pc_reg #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .redir_i (redirect),
    .tgt_i   (eff_tgt),
    .pc_o    (pc_o)
  );

  assign slot_o        = cur_slot;
  assign fetch_valid_o = !((cur_slot != '0) && eff_kill);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_br_o <= 1'b0;
    else         bad_br_o <= br_ill;
  end

  a_r8_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && $past(slot_o) != '0) |=> bad_br_o);

  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> !bad_br_o);

  a_r6_annul_only_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o |-> (slot_o != '0));

  a_r5_plain_keeps_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_acc && !br_likely_i) |-> fetch_valid_o);

  a_r7_taken_keeps_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != '0 && eff_taken) |-> fetch_valid_o);
endmodule

// File: tb/dbs_fetch_seq_tb.sv
`timescale 1ns/1ps
module dbs_fetch_seq_tb;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_v = 1'b0, br_t = 1'b0, br_l = 1'b0;
  logic [31:0] br_tgt = '0;
  logic [31:0] pc;
  logic        fv, bad;
  logic [1:0]  slot;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dbs_fetch_seq #(.AW(32), .NUM_SLOTS(2), .RESET_VEC(RV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_v), .br_taken_i(br_t),
    .br_likely_i(br_l), .br_target_i(br_tgt), .pc_o(pc),
    .fetch_valid_o(fv), .slot_o(slot), .bad_br_o(bad)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic fetch(string tag, logic [31:0] e_pc, logic [1:0] e_slot,
                       logic e_fv, logic e_bad);
    chk({tag, " pc"}, pc, e_pc);
    chk({tag, " slot"}, {30'd0, slot}, {30'd0, e_slot});
    chk({tag, " valid"}, {31'd0, fv}, {31'd0, e_fv});
    chk({tag, " err"}, {31'd0, bad}, {31'd0, e_bad});
  endtask

  task automatic cyc(logic v, logic t, logic l, logic [31:0] tg);
    @(negedge clk);
    br_v = v; br_t = t; br_l = l; br_tgt = tg;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; br_v = 0; br_t = 0; br_l = 0; br_tgt = '0;
    #1;
    fetch("R1 in reset", RV, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    fetch("R1 after reset", RV, 2'd0, 1'b1, 1'b0);
  endtask

  // branch at RV+4, reported while RV+8 is fetched
  task automatic t_branch(string tag, logic t, logic l, logic [31:0] tg,
                          logic e_fv, logic [31:0] e_after);
    do_reset();
    cyc(0, 0, 0, '0);
    fetch({tag, " R2 branch fetch"}, RV + 4, 2'd0, 1'b1, 1'b0);
    cyc(1, t, l, tg);
    fetch({tag, " R3 slot1"}, RV + 8, 2'd1, e_fv, 1'b0);
    cyc(0, 0, 0, '0);
    fetch({tag, " R3 slot2"}, RV + 12, 2'd2, e_fv, 1'b0);
    cyc(0, 0, 0, '0);
    fetch({tag, " R4 after shadow"}, e_after, 2'd0, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch({tag, " R2 continue"}, e_after + 4, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_illegal();
    do_reset();
    cyc(0, 0, 0, '0);
    cyc(1, 1, 0, 32'h200);
    fetch("R8 legal slot1", RV + 8, 2'd1, 1'b1, 1'b0);
    cyc(1, 1, 1, 32'h400);
    fetch("R8 report from slot1", RV + 12, 2'd2, 1'b1, 1'b0);
    cyc(1, 0, 1, 32'h600);
    fetch("R8 target kept", 32'h200, 2'd0, 1'b1, 1'b1);
    cyc(0, 0, 0, '0);
    fetch("R8 second pulse", 32'h204, 2'd0, 1'b1, 1'b1);
    cyc(0, 0, 0, '0);
    fetch("R8 pulse ends", 32'h208, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    cyc(0, 0, 0, '0);
    cyc(1, 1, 0, 32'h300);
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, '0);
    fetch("R11 first target", 32'h300, 2'd0, 1'b1, 1'b0);
    cyc(1, 1, 0, 32'h500);
    fetch("R11 second slot1", 32'h304, 2'd1, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch("R11 second slot2", 32'h308, 2'd2, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch("R11 second target", 32'h500, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_reset_in_shadow();
    do_reset();
    cyc(0, 0, 0, '0);
    cyc(1, 1, 0, 32'h700);
    fetch("R10 slot1 before reset", RV + 8, 2'd1, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; br_v = 0; br_t = 0; br_l = 0; br_tgt = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    fetch("R10 restart", RV, 2'd0, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch("R10 seq1", RV + 4, 2'd0, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch("R10 seq2", RV + 8, 2'd0, 1'b1, 1'b0);
    cyc(0, 0, 0, '0);
    fetch("R10 no stale jump", RV + 12, 2'd0, 1'b1, 1'b0);
  endtask

  initial begin
    t_branch("R4 R5 plain taken", 1'b1, 1'b0, 32'h200, 1'b1, 32'h200);
    t_branch("R5 plain not taken", 1'b0, 1'b0, 32'h200, 1'b1, RV + 16);
    t_branch("R6 likely not taken", 1'b0, 1'b1, 32'h200, 1'b0, RV + 16);
    t_branch("R7 likely taken", 1'b1, 1'b1, 32'h240, 1'b1, 32'h240);
    t_branch("R9 unaligned target", 1'b1, 1'b0, 32'h283, 1'b1, 32'h280);
    t_illegal();
    t_back_to_back();
    t_reset_in_shadow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule